// File: doc/BRIEF.md
# Serial Command Port with Status Readout and Pass-Through

This block is the serial command port of a power-driver controller. The bus master pulls chip select low and clocks a frame of any length, most significant bit first. The first eight bits the block returns are a status byte. That byte is a snapshot of the fault inputs, taken when chip select falls. After the status byte, the block returns the bits it received earlier in the same frame, eight bit-times later. This lets several ports share one daisy chain.

When chip select goes high, the block latches the eight most recently received bits into its control register. Earlier bytes of a long frame only pass through to the output. A frame shorter than eight bits leaves the control register untouched.

The serial data output is meant for a tri-state pad. The block supplies the data bit and an output enable. The enable is high only while chip select is low, at least one enable input is high and every supply-valid input is high. The block also gives a one-cycle update strobe in the system clock domain. The serial bus cannot be stalled, so this strobe has no back-pressure: downstream logic must accept it in the cycle it appears.

Top module: `spi_wrap_slave`

## Requirements
- R1: Chip select is active low. Serial clock edges seen while chip select is high do not count toward a frame. A frame with no clock edges, sent after such edges, leaves the control register unchanged and gives no update strobe.
- R2: The status byte is captured from the status input on the falling edge of chip select. Its bit 7 is on the data output before the first rising serial clock edge. Bits 6 down to 0 follow, each changing on a falling serial clock edge. Changes to the status input after chip select falls have no effect on the byte sent.
- R3: From the eighth falling serial clock edge onward, the data output carries the data-input bits of the same frame in arrival order. Bit n of the output is data-input bit n-8, where bits are counted from 0 at the start of the frame.
- R4: Data input is sampled on rising serial clock edges. When chip select rises after eight or more bits, the control register takes the last eight bits received. The earliest of those eight becomes bit 7.
- R5: When chip select rises after fewer than eight bits, the control register keeps its value and no update strobe is given.
- R6: The output enable is high exactly when chip select is low, at least one enable input is high and all supply-valid inputs are high. While the enable is low, the data output is 0.
- R7: The active-low reset clears the control register to zero at once, without waiting for a clock edge, and holds the update strobe low.
- R8: After a frame that updated the control register, the update strobe is high for exactly one system clock cycle. It goes high on the second rising system clock edge after chip select rises, and the control register is stable while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the update strobe |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock (idle low) |
| cs_ni | input | 1 | Chip select, active low |
| di_i | input | 1 | Serial data input |
| status_i | input | W | Fault and temperature flags for the status byte |
| enable_i | input | NUM_EN | Enable inputs; any one high allows output |
| supply_ok_i | input | NUM_SUP | Supply-valid flags; all must be high to allow output |
| do_o | output | 1 | Serial data output bit, 0 while not enabled |
| do_oe_o | output | 1 | Output enable for the external tri-state pad |
| ctrl_o | output | W | Control register |
| ctrl_upd_o | output | 1 | One-cycle strobe marking a control register update |

## Verification
The output enable and the first status bit are combinational. They are checked while the serial clock is low, with no edge in between. Every later output bit is produced by a falling serial clock edge and is read one system cycle after that edge, still ahead of the next rising edge. The control register changes at the chip-select rising edge and is read a few cycles later. The update strobe is due on the second system clock edge after chip select rises, so the bench checks it on the falling system edges after the first, second and third rising edges: it must be low, then high, then low. The reset check drops reset between clock edges and reads the control register before any edge arrives.

// File: rtl/spi_wrap_pkg.sv
package spi_wrap_pkg;
  localparam int SPI_BYTE_W = 8;
  localparam int SPI_EN_N   = 2;
  localparam int SPI_SUP_N  = 2;
  localparam int SYNC_DEPTH = 3;
endpackage

// File: rtl/spi_wrap_shift.sv
module spi_wrap_shift #(
  parameter int W = spi_wrap_pkg::SPI_BYTE_W
) (
  input  logic         sclk_i,
  input  logic         cs_n_i,
  input  logic         di_i,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] rx_o,
  output logic         full_o,
  output logic         do_bit_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  status_q;
  logic [W-1:0]  rx_q;
  logic [W-1:0]  st_sh;
  logic [CW-1:0] rcnt_q;
  logic [CW-1:0] fcnt_q;
  logic          do_q;
  logic          do_nxt;

  // status snapshot at frame start
  always_ff @(negedge cs_n_i) status_q <= status_i;

  // rising-edge bit counter, saturating at W, cleared while deselected
  always_ff @(posedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i)                   rcnt_q <= '0;
    else if (rcnt_q != CW'(W))    rcnt_q <= rcnt_q + 1'b1;
  end

  // receive path doubles as the pass-through delay line
  always_ff @(posedge sclk_i) begin
    if (!cs_n_i) rx_q <= {rx_q[W-2:0], di_i};
  end

  always_comb begin
    st_sh  = status_q << (fcnt_q + 1'b1);
    do_nxt = (fcnt_q < CW'(W - 1)) ? st_sh[W-1] : rx_q[W-1];
  end

  // output changes on the falling edge
  always_ff @(negedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i) begin
      fcnt_q <= '0;
      do_q   <= 1'b0;
    end else begin
      if (fcnt_q != CW'(W)) fcnt_q <= fcnt_q + 1'b1;
      do_q <= do_nxt;
    end
  end

  assign do_bit_o = (fcnt_q == '0) ? status_q[W-1] : do_q;
  assign rx_o     = rx_q;
  assign full_o   = (rcnt_q == CW'(W));
endmodule

// File: rtl/spi_wrap_ctrl_latch.sv
module spi_wrap_ctrl_latch #(
  parameter int W = spi_wrap_pkg::SPI_BYTE_W
) (
  input  logic         cs_n_i,
  input  logic         rst_ni,
  input  logic         full_i,
  input  logic [W-1:0] rx_i,
  output logic [W-1:0] ctrl_o,
  output logic         upd_valid_o
);
  always_ff @(posedge cs_n_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= '0;
      upd_valid_o <= 1'b0;
    end else begin
      upd_valid_o <= full_i;
      if (full_i) ctrl_o <= rx_i;
    end
  end
endmodule

// File: rtl/spi_wrap_upd_sync.sv
module spi_wrap_upd_sync #(
  parameter int W     = spi_wrap_pkg::SPI_BYTE_W,
  parameter int DEPTH = spi_wrap_pkg::SYNC_DEPTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_n_i,
  input  logic         upd_valid_i,
  input  logic [W-1:0] ctrl_i,
  output logic         pulse_o
);
  logic [DEPTH-1:0] cs_sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_sync_q <= '1;
    else         cs_sync_q <= {cs_sync_q[DEPTH-2:0], cs_n_i};
  end

  assign pulse_o = cs_sync_q[DEPTH-2] & ~cs_sync_q[DEPTH-1] & upd_valid_i;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R8
  AST_CTRL_SETTLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $stable(ctrl_i)); // R8
  AST_CTRL_ONLY_ON_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_i) |-> upd_valid_i); // R5
endmodule

// File: rtl/spi_wrap_slave.sv
module spi_wrap_slave #(
  parameter int W       = spi_wrap_pkg::SPI_BYTE_W,
  parameter int NUM_EN  = spi_wrap_pkg::SPI_EN_N,
  parameter int NUM_SUP = spi_wrap_pkg::SPI_SUP_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               di_i,
  input  logic [W-1:0]       status_i,
  input  logic [NUM_EN-1:0]  enable_i,
  input  logic [NUM_SUP-1:0] supply_ok_i,
  output logic               do_o,
  output logic               do_oe_o,
  output logic [W-1:0]       ctrl_o,
  output logic               ctrl_upd_o
);
  logic [W-1:0] rx;
  logic         full;
  logic         do_bit;
  logic         upd_valid;

  spi_wrap_shift #(.W(W)) u_shift (
    .sclk_i(sclk_i), .cs_n_i(cs_ni), .di_i(di_i), .status_i(status_i),
    .rx_o(rx), .full_o(full), .do_bit_o(do_bit)
  );

  spi_wrap_ctrl_latch #(.W(W)) u_latch (
    .cs_n_i(cs_ni), .rst_ni(rst_ni), .full_i(full), .rx_i(rx),
    .ctrl_o(ctrl_o), .upd_valid_o(upd_valid)
  );

  spi_wrap_upd_sync #(.W(W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_ni), .upd_valid_i(upd_valid),
    .ctrl_i(ctrl_o), .pulse_o(ctrl_upd_o)
  );

  assign do_oe_o = ~cs_ni & (|enable_i) & (&supply_ok_i);
  assign do_o    = do_oe_o & do_bit;

  AST_NO_OE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !do_oe_o); // R6
endmodule

// File: tb/sim_spi_wrap_slave.sv
module sim_spi_wrap_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       di = 1'b0;
  logic [7:0] status = 8'h00;
  logic [1:0] en = 2'b11;
  logic [1:0] sup = 2'b11;
  logic       do_bit, do_oe, upd;
  logic [7:0] ctrl;

  int n_chk = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  logic [7:0] exp_ctrl = 8'h00;

  always #4 clk = ~clk;

  spi_wrap_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .di_i(di),
    .status_i(status), .enable_i(en), .supply_ok_i(sup),
    .do_o(do_bit), .do_oe_o(do_oe), .ctrl_o(ctrl), .ctrl_upd_o(upd)
  );

  always @(posedge clk) if (upd) pulse_cnt <= pulse_cnt + 1;

  // {status, bit count, frame data right-aligned, first bit = MSB of count}
  localparam logic [45:0] TBL [6] = '{
    {8'hA5, 6'd8,  32'h0000003C},
    {8'h0F, 6'd16, 32'h000012F0},
    {8'h80, 6'd24, 32'h00ABCDEF},
    {8'hFF, 6'd5,  32'h00000015},
    {8'h00, 6'd9,  32'h00000155},
    {8'h5A, 6'd12, 32'h00000C33}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] st, input int nbits, input logic [31:0] data);
    logic [7:0]  got_st = '0, exp_st = '0;
    logic [31:0] got_wr = '0, exp_wr = '0;
    logic        b;
    status = st;
    tick(1);
    cs_n = 1'b0;
    tick(1);
    status = ~st;                       // R2: late change must be ignored
    tick(1);
    chk("R2", "first bit before clock", {31'd0, do_bit}, {31'd0, st[7]});
    chk("R6", "oe while selected", {31'd0, do_oe}, 32'd1);
    for (int i = 0; i < nbits; i++) begin
      b  = data[nbits-1-i];
      di = b;
      if (i < 8) begin
        got_st = {got_st[6:0], do_bit};
        exp_st = {exp_st[6:0], st[7-i]};
      end else begin
        got_wr = {got_wr[30:0], do_bit};
        exp_wr = {exp_wr[30:0], data[nbits-1-(i-8)]};
      end
      tick(1);
      sclk = 1'b1;
      tick(2);
      sclk = 1'b0;
      tick(1);
    end
    chk("R2", "status byte stream", {24'd0, got_st}, {24'd0, exp_st});
    if (nbits > 8) chk("R3", "pass-through stream", got_wr, exp_wr);
    cs_n = 1'b1;
    if (nbits >= 8) exp_ctrl = data[7:0];
    tick(1);
    chk("R8", "strobe low after first edge", {31'd0, upd}, 32'd0);
    tick(1);
    chk(nbits >= 8 ? "R8" : "R5", "strobe at second edge", {31'd0, upd},
        {31'd0, nbits >= 8});
    tick(1);
    chk("R8", "strobe low at third edge", {31'd0, upd}, 32'd0);
    chk(nbits >= 8 ? "R4" : "R5", "control register", {24'd0, ctrl}, {24'd0, exp_ctrl});
    tick(2);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int pc;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R7", "ctrl after reset", {24'd0, ctrl}, 32'd0);
    chk("R7", "strobe after reset", {31'd0, upd}, 32'd0);
    chk("R6", "oe while deselected", {31'd0, do_oe}, 32'd0);

    for (int k = 0; k < 6; k++)
      frame(TBL[k][45:38], int'(TBL[k][37:32]), TBL[k][31:0]);

    // R1: clocks with chip select high, then an empty frame
    pc = pulse_cnt;
    di = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
    end
    cs_n = 1'b0; tick(2); cs_n = 1'b1; tick(5);
    chk("R1", "ctrl after deselected clocks", {24'd0, ctrl}, {24'd0, exp_ctrl});
    chk("R1", "no strobe after deselected clocks", pulse_cnt, pc);

    // R6: enable and supply gating
    cs_n = 1'b0;
    en = 2'b00; tick(1);
    chk("R6", "oe with no enable", {31'd0, do_oe}, 32'd0);
    en = 2'b10; tick(1);
    chk("R6", "oe with one enable", {31'd0, do_oe}, 32'd1);
    sup = 2'b01; tick(1);
    chk("R6", "oe with supply low", {31'd0, do_oe}, 32'd0);
    chk("R6", "data low while disabled", {31'd0, do_bit}, 32'd0);
    sup = 2'b11; en = 2'b11;
    cs_n = 1'b1; tick(5);
    chk("R5", "empty frame keeps ctrl", {24'd0, ctrl}, {24'd0, exp_ctrl});

    // R7: asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 chk("R7", "async clear", {24'd0, ctrl}, 32'd0);
    tick(2);
    rst_n = 1'b1;
    tick(2);
    exp_ctrl = 8'h00;
    frame(8'hC3, 8, 32'h96);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule